// File: doc/BRIEF.md
# Configurable Logic Cell with Optional Storage

This block models one programmable logic cell. Its combinational part is a four-way data selector whose two select lines are not driven directly: the low select is the AND of one pair of control inputs and the high select is the OR of a second pair. A single cell can therefore realise wide AND or OR terms, or a multiplexer, depending on how its data inputs are tied.

The selector result can go straight to the output. It can also feed a storage element with no logic stage in between. Static configuration inputs pick one of three behaviours for that element: bypassed, a level-sensitive latch, or a rising-edge flip-flop. They also pick which of three clock inputs drives it: two routed clocks and one dedicated array clock. An active-high asynchronous clear forces the stored value to zero.

Top module: `logic_cell`

## Requirements
- R1: The low select term equals `a0 AND b0`.
- R2: The high select term equals `a1 OR b1`.
- R3: The selector result is `din[{hi,lo}]`, where hi and lo are the select terms. With hi=0 and lo=0 it is `din[0]`, with hi=0 and lo=1 it is `din[1]`, with hi=1 and lo=0 it is `din[2]`, and with hi=1 and lo=1 it is `din[3]`.
- R4: With `mode` equal to 0 (bypass) or 3 (also bypass), `y` follows the selector result with no clock.
- R5: With `mode` equal to 2 (flip-flop), `y` takes the selector result on a rising edge of the selected clock and holds it at all other times.
- R6: With `mode` equal to 1 (latch), `y` follows the selector result while the selected clock is high and holds its last value while it is low.
- R7: In latch and flip-flop modes, a high `clr` forces `y` to 0 at once, whatever the clock is doing.
- R8: `clk_sel` picks the clock for the storage element: 0 picks `clk_r0`, 1 picks `clk_r1`, 2 picks `clk_arr`, and 3 picks `clk_r0`. The clocks that are not selected have no effect on `y`.
- R9: Once `clr` is released, the flip-flop keeps 0 until the next rising edge of the selected clock, and it captures again on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 4 | Data inputs, indexed by {hi select, lo select} |
| a0 | input | 1 | First input of the AND select term |
| b0 | input | 1 | Second input of the AND select term |
| a1 | input | 1 | First input of the OR select term |
| b1 | input | 1 | Second input of the OR select term |
| clk_r0 | input | 1 | Routed clock 0 |
| clk_r1 | input | 1 | Routed clock 1 |
| clk_arr | input | 1 | Dedicated array clock |
| clr | input | 1 | Asynchronous clear, active high |
| clk_sel | input | 2 | Clock choice (0 and 3: routed 0, 1: routed 1, 2: array) |
| mode | input | 2 | Storage behaviour (0 and 3: bypass, 1: latch, 2: flip-flop) |
| y | output | 1 | Cell output |

## Verification
The assertions are clocked by the selected clock itself. They assume that `mode` and `clk_sel` change only while every clock input is low, so that a reconfiguration never creates a false edge. They also assume that the data and control inputs are steady around each edge of the selected clock. The flip-flop check further assumes that whenever clear is used in flip-flop mode, it is held across at least one rising edge of the selected clock. The bench changes configuration only with all clocks parked low, moves data only between edges, and wraps every clear in such an edge.

// File: rtl/logic_cell.sv
module logic_cell #(
  parameter int NSEL = 3
) (
  input  logic [3:0] din,
  input  logic       a0,
  input  logic       b0,
  input  logic       a1,
  input  logic       b1,
  input  logic       clk_r0,
  input  logic       clk_r1,
  input  logic       clk_arr,
  input  logic       clr,
  input  logic [1:0] clk_sel,
  input  logic [1:0] mode,
  output logic       y
);
  localparam logic [1:0] MODE_LATCH = 2'd1;
  localparam logic [1:0] MODE_FF    = 2'd2;

  logic       sel_lo, sel_hi, comb_y, sel_clk;
  logic       lat_q, ff_q;
  logic [NSEL-1:0] clk_vec;

  assign sel_lo  = a0 & b0;
  assign sel_hi  = a1 | b1;
  assign comb_y  = din[{sel_hi, sel_lo}];

  assign clk_vec = {clk_arr, clk_r1, clk_r0};
  assign sel_clk = (clk_sel == 2'd3) ? clk_vec[0] : clk_vec[clk_sel];

  always_latch begin
    if (clr)          lat_q = 1'b0;
    else if (sel_clk) lat_q = comb_y;
  end

  always_ff @(posedge sel_clk or posedge clr) begin
    if (clr) ff_q <= 1'b0;
    else     ff_q <= comb_y;
  end

  always_comb begin
    case (mode)
      MODE_LATCH: y = lat_q;
      MODE_FF:    y = ff_q;
      default:    y = comb_y;
    endcase
  end

  AST_BYPASS_FOLLOWS: assert property (@(posedge sel_clk) disable iff (clr)
    (mode == 2'd0 || mode == 2'd3) |-> (y == din[{a1 | b1, a0 & b0}])); // R4

  AST_AND_TERM_PICKS_D01: assert property (@(posedge sel_clk) disable iff (clr)
    ((mode == 2'd0) && a0 && b0 && !a1 && !b1) |-> (y == din[1])); // R1

  AST_FF_CAPTURE: assert property (@(posedge sel_clk) disable iff (clr)
    (mode == MODE_FF) ##1 (mode == MODE_FF) |-> (y == $past(comb_y))); // R5

  AST_LATCH_TRANSPARENT: assert property (@(negedge sel_clk) disable iff (clr)
    (mode == MODE_LATCH) |-> (y == comb_y)); // R6
endmodule

// File: tb/logic_cell_tb.sv
module logic_cell_tb;
  logic       clk = 1'b0;
  logic [3:0] din = '0;
  logic       a0 = 0, b0 = 0, a1 = 0, b1 = 0;
  logic       clk_r0 = 0, clk_r1 = 0, clk_arr = 0, clr = 0;
  logic [1:0] clk_sel = '0, mode = '0;
  logic       y;
  int         n_run = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  logic_cell u_dut (.din(din), .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .clk_r0(clk_r0), .clk_r1(clk_r1), .clk_arr(clk_arr), .clr(clr),
    .clk_sel(clk_sel), .mode(mode), .y(y));

  task automatic chk(input string req, input logic exp);
    n_run++;
    if (y !== exp) begin
      n_fail++;
      $display("FAIL %s: y=%b expected %b", req, y, exp);
    end
  endtask

  task automatic drive_clk(input int which, input logic v);
    case (which)
      0: clk_r0 = v;
      1: clk_r1 = v;
      default: clk_arr = v;
    endcase
  endtask

  task automatic pulse(input int which);
    drive_clk(which, 1'b1); #5;
    drive_clk(which, 1'b0); #5;
  endtask

  task automatic cleared_edge(input int which);
    clr = 1'b1; #2;
    pulse(which);
    clr = 1'b0; #2;
  endtask

  task automatic t_reset;
    mode = 2'd2; clk_sel = 2'd0;
    clr = 1'b1; #2;
    chk("R7 reset", 1'b0);
    pulse(0);
    clr = 1'b0; #2;
    chk("R9 after release", 1'b0);
  endtask

  task automatic t_select;
    logic lo, hi;
    mode = 2'd0;
    for (int i = 0; i < 256; i++) begin
      {din, a0, b0, a1, b1} = i[7:0]; #2;
      lo = a0 & b0; hi = a1 | b1;
      chk("R3 select", din[{hi, lo}]);
    end
    din = 4'b0010; a1 = 0; b1 = 0;
    a0 = 1; b0 = 0; #2; chk("R1 and-term low", 1'b0);
    a0 = 1; b0 = 1; #2; chk("R1 and-term high", 1'b1);
    din = 4'b0100; a0 = 0; b0 = 0;
    a1 = 0; b1 = 1; #2; chk("R2 or-term high", 1'b1);
    a1 = 0; b1 = 0; #2; chk("R2 or-term low", 1'b0);
    mode = 2'd3;
    for (int i = 0; i < 16; i++) begin
      din = i[3:0]; a0 = 1; b0 = 1; a1 = 1; b1 = 0; #2;
      chk("R4 mode3 bypass", din[3]);
    end
    {a0, b0, a1, b1} = '0;
  endtask

  task automatic t_ff;
    mode = 2'd2; clk_sel = 2'd0; din = 4'b0000; #2;
    cleared_edge(0);
    din[0] = 1'b1; #2;   chk("R5 no edge", 1'b0);
    clk_r0 = 1'b1; #2;   chk("R5 rising edge", 1'b1);
    din[0] = 1'b0; #2;   chk("R5 hold while high", 1'b1);
    clk_r0 = 1'b0; #2;   chk("R5 falling edge ignored", 1'b1);
    pulse(0);            chk("R5 next edge", 1'b0);
  endtask

  task automatic t_latch;
    mode = 2'd1; clk_sel = 2'd1; din = 4'b0000; #2;
    cleared_edge(1);
    din[0] = 1'b1; #2;   chk("R6 closed", 1'b0);
    clk_r1 = 1'b1; #2;   chk("R6 open", 1'b1);
    din[0] = 1'b0; #2;   chk("R6 transparent low", 1'b0);
    din[0] = 1'b1; #2;   chk("R6 transparent high", 1'b1);
    clk_r1 = 1'b0; #2;
    din[0] = 1'b0; #2;   chk("R6 hold", 1'b1);
  endtask

  task automatic t_clear;
    mode = 2'd2; clk_sel = 2'd0; din = 4'b0001; #2;
    pulse(0);            chk("R5 preload", 1'b1);
    clr = 1'b1; #2;      chk("R7 async ff", 1'b0);
    pulse(0);            chk("R7 overrides edge", 1'b0);
    clr = 1'b0; #2;      chk("R9 stays zero", 1'b0);
    pulse(0);            chk("R9 recapture", 1'b1);
    clk_r0 = 1'b0; mode = 2'd1; #2;
    clk_r0 = 1'b1; #2;   chk("R6 latch open", 1'b1);
    clr = 1'b1; #2;      chk("R7 async latch", 1'b0);
    clk_r0 = 1'b0; #2;
    clr = 1'b0; #2;      chk("R7 latch stays clear", 1'b0);
  endtask

  task automatic t_clksel;
    mode = 2'd2; clk_sel = 2'd2; din = 4'b0000; #2;
    cleared_edge(2);
    din[0] = 1'b1; #2;
    pulse(0);            chk("R8 r0 ignored", 1'b0);
    pulse(1);            chk("R8 r1 ignored", 1'b0);
    pulse(2);            chk("R8 array clock", 1'b1);
    clk_sel = 2'd3; din[0] = 1'b0; #2;
    pulse(2);            chk("R8 array ignored in 3", 1'b1);
    pulse(1);            chk("R8 r1 ignored in 3", 1'b1);
    pulse(0);            chk("R8 value 3 uses r0", 1'b0);
    clk_sel = 2'd1; din[0] = 1'b1; #2;
    pulse(0);            chk("R8 r0 ignored in 1", 1'b0);
    pulse(1);            chk("R8 r1 selected", 1'b1);
  endtask

  initial begin
    #3;
    t_reset();
    t_select();
    t_ff();
    t_latch();
    t_clear();
    t_clksel();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: cycles=%0d expected done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule